// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits between an interrupt source layer and one processor core. It holds a single pending slot (source number plus priority), a current processor priority and an interprocessor-interrupt priority. It drives one level interrupt line to the core. Software works on it through four register operations: set processor priority, set IPI priority, accept and end-of-interrupt.

The source layer offers interrupts one at a time, each with a source number and a priority. The block either takes the offer into the slot or bounces it back as a reject. A more favored offer, or a more favored IPI, displaces the entry already in the slot, and that entry is returned to the source layer as a reject. When the processor becomes able to take more work, the block asks the source layer to re-offer anything it is holding. A lower number means a more favored priority, and 0xFF means masked.

Reject, resend and end-of-interrupt notifications, and the accept result, come out as registered single-cycle pulses. They appear one cycle after the event that causes them. When a register operation and an offer arrive in the same cycle, the operation is applied first and the offer is evaluated against the updated state.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the line is low, the processor priority is 0, nothing is pending and the IPI priority is 0xFF. An accept then returns 0x00000000.
- R2: An offer whose priority is strictly below the processor priority, arriving while the slot is empty, is latched and raises `irq_o` on the next cycle.
- R3: An offer whose priority is equal to or above the processor priority is rejected on the offer reject channel with its own source number, and the slot is left unchanged.
- R4: If an entry is pending at a priority equal to or better than an offer, the offer is rejected. If the offer is strictly better, the pending entry is rejected on the offer reject channel and the offer takes the slot.
- R5: Accept (op code 2) returns {processor priority[31:24], pending source[23:0]} on `acc_data_o` and drops the line. It then sets the processor priority to the pending priority and the source to 0.
- R6: Set IPI (op code 1, priority in data bits 7:0) stores the IPI priority. If that priority is below the processor priority and the slot is not held at an equal or better priority, the slot takes source `IPI_SRC` at the IPI priority and the line rises. Any entry it displaces is rejected on the operation reject channel.
- R7: Set processor priority (op code 0, priority in data bits 7:0) to a smaller value clears a pending entry whose priority is equal to or greater than the new value. The line drops and the entry is rejected on the operation reject channel. A pending entry of better priority is kept.
- R8: Setting the processor priority to an equal or larger value while nothing is pending pulses `resend_o`. Before that, the IPI is re-checked when the IPI priority is below the new processor priority.
- R9: End-of-interrupt (op code 3) loads the processor priority from data bits 31:24 and pulses `eoi_valid_o` with data bits 23:0. If nothing is pending it also resends, with the IPI re-check of R8.
- R10: A register operation in the same cycle as an offer is applied before the offer is evaluated. Both reject channels may pulse in one cycle.
- R11: Every notification and accept result is a single-cycle pulse one clock after its cause, and no notification appears without a cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Register operation strobe |
| op_code_i | input | 2 | 0 set priority, 1 set IPI, 2 accept, 3 end-of-interrupt |
| op_data_i | input | 32 | Operation data |
| offer_valid_i | input | 1 | Source layer offers an interrupt |
| offer_src_i | input | 24 | Offered source number (non-zero) |
| offer_prio_i | input | 8 | Offered priority |
| irq_o | output | 1 | Interrupt line to the core |
| acc_valid_o | output | 1 | Accept result valid |
| acc_data_o | output | 32 | Accept result {priority, source} |
| rej_op_valid_o | output | 1 | Reject caused by a register operation |
| rej_op_src_o | output | 24 | Source rejected by the operation |
| rej_ofr_valid_o | output | 1 | Reject caused by offer evaluation |
| rej_ofr_src_o | output | 24 | Source rejected by the offer |
| resend_o | output | 1 | Ask the source layer to re-offer |
| eoi_valid_o | output | 1 | End-of-interrupt notification |
| eoi_src_o | output | 24 | Source number being completed |

## Verification
The bench goes after the priority boundaries. An offer equal to the processor priority must bounce; an off-by-one compare would latch it and raise the line. An offer equal to the pending priority must not displace the pending entry; a wrong compare would reject the wrong source. It exercises a restrictive priority write that clears, or keeps, the pending entry, and an end-of-interrupt whose resend revives the IPI. A design that swapped channels or skipped the re-check would show a missing line or the wrong pulses. Same-cycle operation/offer pairs expose an evaluation order flipped from R10: the wrong source appears on the wrong reject channel, or the line is left high.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned SRC_W  = 24;
  localparam int unsigned XIRR_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } op_e;

  typedef struct packed {
    logic [PRIO_W-1:0] cppr;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] pend;
    logic [PRIO_W-1:0] ipi;
    logic              line;
  } slot_t;

  typedef struct packed {
    logic             vld;
    logic [SRC_W-1:0] src;
  } note_t;
endpackage

// File: rtl/irq_op_stage.sv
module irq_op_stage
  import irq_pres_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  slot_t              st_i,
  input  logic               op_valid_i,
  input  op_e                op_code_i,
  input  logic [XIRR_W-1:0]  op_data_i,
  output slot_t              st_o,
  output note_t              rej_o,
  output logic               resend_o,
  output note_t              eoi_o,
  output logic               acc_vld_o,
  output logic [XIRR_W-1:0]  acc_data_o
);
  logic [PRIO_W-1:0] lo_prio;
  logic [PRIO_W-1:0] hi_prio;
  logic              do_ipi;
  slot_t             s;
  note_t             rej;

  assign lo_prio = op_data_i[PRIO_W-1:0];
  assign hi_prio = op_data_i[XIRR_W-1:SRC_W];

  always_comb begin
    s          = st_i;
    rej        = '0;
    resend_o   = 1'b0;
    eoi_o      = '0;
    acc_vld_o  = 1'b0;
    acc_data_o = '0;
    do_ipi     = 1'b0;
    if (op_valid_i) begin
      unique case (op_code_i)
        OP_SET_CPPR: begin
          s.cppr = lo_prio;
          if (lo_prio < st_i.cppr) begin
            if ((st_i.src != '0) && (lo_prio <= st_i.pend)) begin
              rej    = '{vld: 1'b1, src: st_i.src};
              s.src  = '0;
              s.line = 1'b0;
            end
          end else if (st_i.src == '0) begin
            resend_o = 1'b1;
            do_ipi   = st_i.ipi < lo_prio;
          end
        end
        OP_SET_IPI: begin
          s.ipi  = lo_prio;
          do_ipi = lo_prio < st_i.cppr;
        end
        OP_ACCEPT: begin
          acc_vld_o  = 1'b1;
          acc_data_o = {st_i.cppr, st_i.src};
          s.line     = 1'b0;
          s.cppr     = st_i.pend;
          s.src      = '0;
        end
        default: begin
          s.cppr = hi_prio;
          eoi_o  = '{vld: 1'b1, src: op_data_i[SRC_W-1:0]};
          if (st_i.src == '0) begin
            resend_o = 1'b1;
            do_ipi   = st_i.ipi < hi_prio;
          end
        end
      endcase
    end
    // IPI contends for the slot; an equal or better holder keeps it
    if (do_ipi && !((s.src != '0) && (s.pend <= s.ipi))) begin
      if (s.src != '0) rej = '{vld: 1'b1, src: s.src};
      s.src  = IPI_SRC;
      s.pend = s.ipi;
      s.line = 1'b1;
    end
  end

  assign st_o  = s;
  assign rej_o = rej;
endmodule

// File: rtl/irq_offer_stage.sv
module irq_offer_stage
  import irq_pres_pkg::*;
(
  input  slot_t             st_i,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  output slot_t             st_o,
  output note_t             rej_o
);
  logic bounce;

  assign bounce = (offer_prio_i >= st_i.cppr) ||
                  ((st_i.src != '0) && (st_i.pend <= offer_prio_i));

  always_comb begin
    st_o  = st_i;
    rej_o = '0;
    if (offer_valid_i) begin
      if (bounce) begin
        rej_o = '{vld: 1'b1, src: offer_src_i};
      end else begin
        if (st_i.src != '0) rej_o = '{vld: 1'b1, src: st_i.src};
        st_o.src  = offer_src_i;
        st_o.pend = offer_prio_i;
        st_o.line = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
  import irq_pres_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_code_i,
  input  logic [XIRR_W-1:0] op_data_i,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  output logic              irq_o,
  output logic              acc_valid_o,
  output logic [XIRR_W-1:0] acc_data_o,
  output logic              rej_op_valid_o,
  output logic [SRC_W-1:0]  rej_op_src_o,
  output logic              rej_ofr_valid_o,
  output logic [SRC_W-1:0]  rej_ofr_src_o,
  output logic              resend_o,
  output logic              eoi_valid_o,
  output logic [SRC_W-1:0]  eoi_src_o
);
  localparam slot_t SLOT_RST = '{cppr: '0, src: '0, pend: '0, ipi: PRIO_MASKED, line: 1'b0};

  slot_t             st_q, st_mid, st_d;
  note_t             rej_op, rej_ofr, eoi_n;
  logic              resend_n, acc_vld_n;
  logic [XIRR_W-1:0] acc_data_n;
  op_e               op_code;

  assign op_code = op_e'(op_code_i);

  irq_op_stage #(.IPI_SRC(IPI_SRC)) u_op (
    .st_i       (st_q),
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code),
    .op_data_i  (op_data_i),
    .st_o       (st_mid),
    .rej_o      (rej_op),
    .resend_o   (resend_n),
    .eoi_o      (eoi_n),
    .acc_vld_o  (acc_vld_n),
    .acc_data_o (acc_data_n)
  );

  // offer sees state after the register operation
  irq_offer_stage u_ofr (
    .st_i          (st_mid),
    .offer_valid_i (offer_valid_i),
    .offer_src_i   (offer_src_i),
    .offer_prio_i  (offer_prio_i),
    .st_o          (st_d),
    .rej_o         (rej_ofr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= SLOT_RST;
      acc_valid_o     <= 1'b0;
      acc_data_o      <= '0;
      rej_op_valid_o  <= 1'b0;
      rej_op_src_o    <= '0;
      rej_ofr_valid_o <= 1'b0;
      rej_ofr_src_o   <= '0;
      resend_o        <= 1'b0;
      eoi_valid_o     <= 1'b0;
      eoi_src_o       <= '0;
    end else begin
      st_q            <= st_d;
      acc_valid_o     <= acc_vld_n;
      acc_data_o      <= acc_data_n;
      rej_op_valid_o  <= rej_op.vld;
      rej_op_src_o    <= rej_op.src;
      rej_ofr_valid_o <= rej_ofr.vld;
      rej_ofr_src_o   <= rej_ofr.src;
      resend_o        <= resend_n;
      eoi_valid_o     <= eoi_n.vld;
      eoi_src_o       <= eoi_n.src;
    end
  end

  assign irq_o = st_q.line;

  // R2
  line_rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(offer_valid_i || op_valid_i));

  // R3
  offer_at_cppr_bounce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offer_valid_i && !op_valid_i && offer_prio_i >= st_q.cppr)
      |=> (rej_ofr_valid_o && rej_ofr_src_o == $past(offer_src_i)));

  // R5
  accept_drops_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'd2 && !offer_valid_i) |=> (!irq_o && acc_valid_o));

  // R6
  ipi_masked_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'd1 && op_data_i[PRIO_W-1:0] >= st_q.cppr && !offer_valid_i)
      |=> (irq_o == $past(irq_o) && !rej_op_valid_o));

  // R9
  eoi_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'd3)
      |=> (eoi_valid_o && eoi_src_o == $past(op_data_i[SRC_W-1:0])));

  // R11
  no_spurious_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && op_code_i == 2'd3) |=> !eoi_valid_o);
endmodule

// File: tb/irq_present_unit_tb.sv
`timescale 1ns/1ps
module irq_present_unit_tb;
  localparam int K_ACC = 0, K_REJOP = 1, K_RESEND = 2, K_EOI = 3, K_REJOF = 4;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] data;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        ofr_valid = 1'b0;
  logic [23:0] ofr_src = '0;
  logic [7:0]  ofr_prio = '0;
  logic        irq;
  logic        acc_valid;
  logic [31:0] acc_data;
  logic        rej_op_valid, rej_ofr_valid, resend, eoi_valid;
  logic [23:0] rej_op_src, rej_ofr_src, eoi_src;

  int   tests = 0;
  int   fails = 0;
  int   ncyc = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  irq_present_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_code_i(op_code), .op_data_i(op_data),
    .offer_valid_i(ofr_valid), .offer_src_i(ofr_src), .offer_prio_i(ofr_prio),
    .irq_o(irq), .acc_valid_o(acc_valid), .acc_data_o(acc_data),
    .rej_op_valid_o(rej_op_valid), .rej_op_src_o(rej_op_src),
    .rej_ofr_valid_o(rej_ofr_valid), .rej_ofr_src_o(rej_ofr_src),
    .resend_o(resend), .eoi_valid_o(eoi_valid), .eoi_src_o(eoi_src)
  );

  task automatic expect_ev(int kind, logic [31:0] data, string req);
    exp_t e;
    e.cyc = ncyc + 1; e.kind = kind; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic seen(int kind, logic [31:0] data);
    tests++;
    if (q.size() > 0 && q[0].cyc == ncyc) begin
      if (q[0].kind != kind || q[0].data != data) begin
        fails++;
        $display("FAIL %s: kind %0d data %h, expected kind %0d data %h",
                 q[0].req, kind, data, q[0].kind, q[0].data);
      end
      void'(q.pop_front());
    end else begin
      fails++;
      $display("FAIL R11: unexpected kind %0d data %h, expected nothing", kind, data);
    end
  endtask

  // monitor: compare output pulses against the expected queue
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (rst_n) begin
      if (acc_valid)     seen(K_ACC, acc_data);
      if (rej_op_valid)  seen(K_REJOP, {8'h0, rej_op_src});
      if (resend)        seen(K_RESEND, 32'h0);
      if (eoi_valid)     seen(K_EOI, {8'h0, eoi_src});
      if (rej_ofr_valid) seen(K_REJOF, {8'h0, rej_ofr_src});
      while (q.size() > 0 && q[0].cyc <= ncyc) begin
        tests++; fails++;
        $display("FAIL %s: missing kind %0d, actual none, expected data %h",
                 q[0].req, q[0].kind, q[0].data);
        void'(q.pop_front());
      end
    end
  end

  task automatic drive(bit ov, logic [1:0] oc, logic [31:0] od,
                       bit fv, logic [23:0] fs, logic [7:0] fp);
    op_valid = ov; op_code = oc; op_data = od;
    ofr_valid = fv; ofr_src = fs; ofr_prio = fp;
    @(negedge clk); #1;
    op_valid = 1'b0; ofr_valid = 1'b0;
  endtask

  task automatic op(logic [1:0] oc, logic [31:0] od);
    drive(1'b1, oc, od, 1'b0, '0, '0);
  endtask

  task automatic offer(logic [23:0] fs, logic [7:0] fp);
    drive(1'b0, 2'd0, '0, 1'b1, fs, fp);
  endtask

  task automatic chk_irq(bit e, string req);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq_o %b expected %b", req, irq, e);
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_irq(1'b0, "R1");
    // R1 reset accept
    expect_ev(K_ACC, 32'h0000_0000, "R1"); op(2'd2, '0); chk_irq(1'b0, "R1");
    // R3 offer not below cppr 0
    expect_ev(K_REJOF, 32'h10, "R3"); offer(24'h10, 8'd5); chk_irq(1'b0, "R3");
    // R8 raise priority with empty slot
    expect_ev(K_RESEND, 32'h0, "R8"); op(2'd0, 32'hFF);
    // R2
    offer(24'h10, 8'd5); chk_irq(1'b1, "R2");
    // R4 equal priority bounces
    expect_ev(K_REJOF, 32'h20, "R4"); offer(24'h20, 8'd5); chk_irq(1'b1, "R4");
    // R4 better offer displaces
    expect_ev(K_REJOF, 32'h10, "R4"); offer(24'h30, 8'd3);
    // R6 IPI not better than pending
    op(2'd1, 32'h4);
    // R6 IPI displaces
    expect_ev(K_REJOP, 32'h30, "R6"); op(2'd1, 32'h1); chk_irq(1'b1, "R6");
    // R5 accept
    expect_ev(K_ACC, 32'hFF00_0002, "R5"); op(2'd2, '0); chk_irq(1'b0, "R5");
    expect_ev(K_ACC, 32'h0100_0000, "R5"); op(2'd2, '0);
    // R2 offer below cppr 1
    offer(24'h40, 8'd0); chk_irq(1'b1, "R2");
    // R7 restrictive priority clears
    expect_ev(K_REJOP, 32'h40, "R7"); op(2'd0, 32'h0); chk_irq(1'b0, "R7");
    // R9 EOI, resend revives IPI prio 1
    expect_ev(K_RESEND, 32'h0, "R8"); expect_ev(K_EOI, 32'h40, "R9");
    op(2'd3, 32'h0600_0040); chk_irq(1'b1, "R9");
    // R7 restrictive but pending better: kept
    op(2'd0, 32'h5); chk_irq(1'b1, "R7");
    op(2'd1, 32'hFF); chk_irq(1'b1, "R6");
    expect_ev(K_ACC, 32'h0500_0002, "R5"); op(2'd2, '0); chk_irq(1'b0, "R5");
    expect_ev(K_RESEND, 32'h0, "R9"); expect_ev(K_EOI, 32'h2, "R9");
    op(2'd3, 32'h0800_0002); chk_irq(1'b0, "R9");
    // R10 op before offer
    expect_ev(K_REJOF, 32'h50, "R10");
    drive(1'b1, 2'd0, 32'h2, 1'b1, 24'h50, 8'd3); chk_irq(1'b0, "R10");
    expect_ev(K_RESEND, 32'h0, "R10");
    drive(1'b1, 2'd0, 32'h10, 1'b1, 24'h60, 8'd7); chk_irq(1'b1, "R10");
    // R3 offer equal to cppr
    expect_ev(K_REJOF, 32'h70, "R3"); offer(24'h70, 8'h10);
    // R10 two rejects in one cycle
    expect_ev(K_REJOP, 32'h60, "R10"); expect_ev(K_REJOF, 32'h80, "R10");
    drive(1'b1, 2'd1, 32'h6, 1'b1, 24'h80, 8'd6);
    expect_ev(K_ACC, 32'h1000_0002, "R5"); op(2'd2, '0); chk_irq(1'b0, "R5");
    // R11 idle cycles: nothing may appear
    repeat (4) drive(1'b0, 2'd0, '0, 1'b0, '0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule